// File: doc/BRIEF.md
# Window Watchdog Timer

This block watches over software that must prove it is alive at the right time, neither too late nor too early. A 7-bit down-counter steps once per prescaled tick. The tick comes from a free-running power-of-two prescaler, followed by a further divide by 1, 2, 4 or 8 that software selects. Once armed, the watchdog raises a one-cycle reset pulse in three cases: the counter falls through 0x40 to 0x3F, software reloads the counter while it still sits above a programmable window ceiling, or software writes the counter with bit 6 clear.

An early-warning flag is raised one count before expiry, so a handler has one tick period to react. This flag can be routed to an interrupt output. A small register port gives write access to three word-aligned registers and combinational read access to them. The arming bit and the interrupt enable are set-only, and only the block reset clears them.

Top module: `win_watchdog`

## Requirements
- R1: The counter decrements once every 2^PRE_LOG2 × 2^tb clock cycles. The prescaler runs freely and is never cleared by writes. tb is configuration bits 8:7.
- R2: While armed, a decrement from 0x40 to 0x3F produces a reset pulse one cycle wide on `wdg_reset_o`, in the cycle after the tick.
- R3: While armed, or while being armed by the same write, a control write made when the pre-write count is greater than the window (configuration bits 6:0) gives a reset pulse in the next cycle. A write made when the count is at or below the window and above 0x3F gives no pulse.
- R4: The arming bit (control bit 7) is cleared by `rst_n` only. Writing 1 sets it, and writing 0 leaves it set.
- R5: The counter keeps decrementing while the block is unarmed, and an unarmed block never pulses `wdg_reset_o`.
- R6: A control write with bit 7 set and bit 6 clear gives a reset pulse in the next cycle.
- R7: Status bit 0 is set when a decrement reaches 0x40, whether or not the interrupt is enabled. Writing 0 to it clears it, and writing 1 has no effect. `early_irq_o` is status bit 0 AND the enable (configuration bit 9).
- R8: After reset the registers read as follows: control (index 0) 0x7F, with the counter in bits 6:0 and arming in bit 7; configuration (index 1) 0x7F; status (index 2) 0. Bits with no field, and index 3, read as 0.
- R9: The interrupt enable (configuration bit 9) is set-only and is cleared only by `rst_n`.
- R10: `wdg_reset_seen_o` rises with the first reset pulse and stays high until `rst_n`.
- R11: A control write in the same cycle as a tick loads the written value, and the decrement is dropped.

Ports, in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W-2 | Word index of the register (0 control, 1 configuration, 2 status) |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wdg_reset_o | output | 1 | Reset request pulse |
| wdg_reset_seen_o | output | 1 | Sticky record of a reset request |
| early_irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with PRE_LOG2 = 2, so one count step takes 4, 8, 16 or 32 clocks instead of thousands. Complete expiries, the early-warning flag and the timer-base settings therefore all fall within a few hundred cycles. This allows each expiry to be timed against the exact window that a free-running prescaler allows. Early and forced resets are timed to the cycle.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W = 7;
  localparam int TB_W  = 2;
  localparam int WR_W  = 10;

  localparam logic [CNT_W-1:0] CNT_RST = 7'h7F;
  localparam logic [CNT_W-1:0] WIN_RST = 7'h7F;
  localparam logic [CNT_W-1:0] WARN_AT = 7'h40;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_CFG  = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;

  // configuration layout: enable bit 9, timer base 8:7, window 6:0
  typedef struct packed {
    logic             ewi;
    logic [TB_W-1:0]  tb;
    logic [CNT_W-1:0] win;
  } cfg_t;

  function automatic logic above_window(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] win);
    return cnt > win;
  endfunction

  function automatic logic at_expiry_edge(logic [CNT_W-1:0] cnt);
    return cnt == WARN_AT;
  endfunction

  function automatic logic at_warn_edge(logic [CNT_W-1:0] cnt);
    return cnt == WARN_AT + 7'd1;
  endfunction
endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int PRE_LOG2 = 12,
  parameter int TB_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tb,
  output logic            tick
);
  localparam int PW = PRE_LOG2 + (1 << TB_W) - 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  function automatic logic [PW-1:0] low_mask(logic [TB_W-1:0] sel);
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = (i < PRE_LOG2 + int'(sel));
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    mask = low_mask(tb);
    tick = ((pre_q & mask) == mask);
  end
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic             wr_act,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt_q,
  output logic             act_q,
  output logic             warn_set,
  output logic             trig_expire,
  output logic             trig_early,
  output logic             trig_forced,
  output logic             reset_q,
  output logic             seen_q
);
  logic act_eff;

  always_comb begin
    act_eff     = act_q | wr_act;
    trig_expire = act_q && tick && !ctrl_wr && at_expiry_edge(cnt_q);
    trig_early  = ctrl_wr && act_eff && above_window(cnt_q, win);
    trig_forced = ctrl_wr && act_eff && !wr_cnt[CNT_W-1];
    warn_set    = tick && !ctrl_wr && at_warn_edge(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_RST;
      act_q   <= 1'b0;
      reset_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (ctrl_wr)   cnt_q <= wr_cnt;
      else if (tick) cnt_q <= cnt_q - 1'b1;
      if (ctrl_wr && wr_act) act_q <= 1'b1;
      reset_q <= trig_expire | trig_early | trig_forced;
      if (trig_expire | trig_early | trig_forced) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wwd_cfgstat.sv
module wwd_cfgstat
  import wwd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            stat_wr,
  input  logic [WR_W-1:0] wdata,
  input  logic            warn_set,
  output cfg_t            cfg_q,
  output logic            flag_q,
  output logic            irq
);
  cfg_t wr_cfg;
  assign wr_cfg = cfg_t'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{ewi: 1'b0, tb: '0, win: WIN_RST};
      flag_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_q.win <= wr_cfg.win;
        cfg_q.tb  <= wr_cfg.tb;
        cfg_q.ewi <= cfg_q.ewi | wr_cfg.ewi;
      end
      if (warn_set)                 flag_q <= 1'b1;
      else if (stat_wr && !wdata[0]) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & cfg_q.ewi;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int PRE_LOG2 = 12,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic [WR_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdg_reset_o,
  output logic              wdg_reset_seen_o,
  output logic              early_irq_o
);
  logic             ctrl_wr, cfg_wr, stat_wr;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q, flag_q;
  logic             warn_set, trig_expire, trig_early, trig_forced;
  cfg_t             cfg_q;

  assign ctrl_wr = bus_we && (bus_addr == IDX_CTRL);
  assign cfg_wr  = bus_we && (bus_addr == IDX_CFG);
  assign stat_wr = bus_we && (bus_addr == IDX_STAT);

  wwd_prescaler #(.PRE_LOG2(PRE_LOG2), .TB_W(TB_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tb(cfg_q.tb), .tick(tick)
  );

  wwd_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
    .wr_act(bus_wdata[CNT_W]), .wr_cnt(bus_wdata[CNT_W-1:0]), .win(cfg_q.win),
    .cnt_q(cnt_q), .act_q(act_q), .warn_set(warn_set),
    .trig_expire(trig_expire), .trig_early(trig_early), .trig_forced(trig_forced),
    .reset_q(wdg_reset_o), .seen_q(wdg_reset_seen_o)
  );

  wwd_cfgstat u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .stat_wr(stat_wr),
    .wdata(bus_wdata), .warn_set(warn_set),
    .cfg_q(cfg_q), .flag_q(flag_q), .irq(early_irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_CTRL: bus_rdata[CNT_W:0] = {act_q, cnt_q};
      IDX_CFG:  bus_rdata[WR_W-1:0] = cfg_q;
      IDX_STAT: bus_rdata[0]        = flag_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
  import wwd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctrl_wr,
  input logic             wr_act,
  input logic [CNT_W-1:0] wr_cnt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] win,
  input logic             act_q,
  input logic             ewi,
  input logic             rst_pulse,
  input logic             seen
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_wr) |=> $stable(cnt_q));
  // R11
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt_q == $past(wr_cnt)));
  // R2
  late_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && tick && !ctrl_wr && cnt_q == WARN_AT) |=> rst_pulse);
  // R3
  early_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (act_q || wr_act) && cnt_q > win) |=> rst_pulse);
  // R4
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> act_q);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !(ctrl_wr && wr_act)) |=> !rst_pulse);
  // R9
  ewi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ewi |=> ewi);
  // R10
  seen_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> seen);
  // R10
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> seen);
endmodule

bind win_watchdog wwd_checker u_wwd_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
  .wr_act(bus_wdata[7]), .wr_cnt(bus_wdata[6:0]), .cnt_q(cnt_q),
  .win(cfg_q.win), .act_q(act_q), .ewi(cfg_q.ewi),
  .rst_pulse(wdg_reset_o), .seen(wdg_reset_seen_o)
);

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;
  localparam int PRE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [9:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdg_reset_o, wdg_reset_seen_o, early_irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  win_watchdog #(.PRE_LOG2(PRE)) u_win_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdg_reset_o(wdg_reset_o),
    .wdg_reset_seen_o(wdg_reset_seen_o), .early_irq_o(early_irq_o)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count negedges after a write until the pulse shows; returns -1 on timeout
  task automatic time_pulse(output int n);
    n = -1;
    for (int i = 1; i <= 400; i++) begin
      if (wdg_reset_o) begin n = i - 1; break; end
      @(negedge clk);
    end
  endtask

  // rows: {index, write data, read mask, read expected}
  localparam int NV = 7;
  localparam logic [75:0] VEC [NV] = '{
    {2'd1, 10'h0D0, 32'hFFFFFFFF, 32'h0000_00D0},  // R8 window and timer base
    {2'd1, 10'h3C0, 32'hFFFFFFFF, 32'h0000_03C0},  // R8 enable set
    {2'd1, 10'h045, 32'hFFFFFFFF, 32'h0000_0245},  // R9 enable stays
    {2'd1, 10'h17F, 32'hFFFFFFFF, 32'h0000_037F},  // R9
    {2'd2, 10'h001, 32'hFFFFFFFF, 32'h0000_0000},  // R7 writing 1 sets nothing
    {2'd0, 10'h000, 32'hFFFFFF80, 32'h0000_0000},  // R4 R5 R6 unarmed, no arming
    {2'd3, 10'h234, 32'hFFFFFFFF, 32'h0000_0000}   // R8 unmapped index
  };

  logic [31:0] d, d2;
  int n;

  initial begin
    bus_addr = 2'd0;
    #1;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;

    // R8 reset state
    rd(2'd0, d); check(d == 32'h7F, "R8 ctrl reset", d, 32'h7F);
    rd(2'd1, d); check(d == 32'h7F, "R8 cfg reset", d, 32'h7F);
    rd(2'd2, d); check(d == 32'h0, "R8 status reset", d, 0);
    check(!wdg_reset_o && !wdg_reset_seen_o && !early_irq_o, "R8 outputs reset",
          {wdg_reset_o, wdg_reset_seen_o, early_irq_o}, 0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][75:74], VEC[v][73:64]);
      rd(VEC[v][75:74], d);
      check((d & VEC[v][63:32]) == VEC[v][31:0], $sformatf("R8 vector %0d", v),
            d & VEC[v][63:32], VEC[v][31:0]);
      check(!wdg_reset_seen_o, $sformatf("R5 vector %0d no reset", v), wdg_reset_seen_o, 0);
    end

    // R5 free-running while unarmed: 40 cycles at 4 per step = 10 steps
    do_reset();
    rd(2'd0, d); wait_cyc(40); rd(2'd0, d2);
    check((d[6:0] - d2[6:0]) == 7'd10, "R5 counts while unarmed", d[6:0] - d2[6:0], 10);

    // R2 late expiry, tb=0: 6 steps from 0x45, pulse in [21,24]
    do_reset();
    wr(2'd0, 10'h0C5);
    time_pulse(n);
    check(n >= 21 && n <= 24, "R2 expiry timing tb0", n, 24);
    @(negedge clk);
    check(!wdg_reset_o, "R2 pulse one cycle", wdg_reset_o, 0);
    wait_cyc(20);
    check(wdg_reset_seen_o, "R10 seen sticky", wdg_reset_seen_o, 1);

    // R1 timer base 2: 4 steps of 16, pulse in [49,64]
    do_reset();
    wr(2'd1, 10'h17F);
    wr(2'd0, 10'h0C3);
    time_pulse(n);
    check(n >= 49 && n <= 64, "R1 expiry timing tb2", n, 64);

    // R3 early reload: count near 0x7F above window 0x50
    do_reset();
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0C5);
    check(wdg_reset_o, "R3 early reload pulse", wdg_reset_o, 1);

    // R3 accepted reload inside window, R4 arming sticky
    do_reset();
    wr(2'd0, 10'h04A);
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0CA);
    wait_cyc(3);
    check(!wdg_reset_seen_o, "R3 in-window reload accepted", wdg_reset_seen_o, 0);
    rd(2'd0, d); check(d[7], "R4 armed", d[7], 1);
    wr(2'd0, 10'h04A);
    rd(2'd0, d); check(d[7], "R4 arming stays set", d[7], 1);
    check(!wdg_reset_seen_o, "R3 second reload accepted", wdg_reset_seen_o, 0);

    // R6 forced reset
    do_reset();
    wr(2'd0, 10'h0BF);
    check(wdg_reset_o, "R6 forced pulse", wdg_reset_o, 1);

    // R7 early-warning flag and interrupt
    do_reset();
    wr(2'd0, 10'h042);
    wait_cyc(10);
    rd(2'd2, d); check(d == 32'h1, "R7 flag set without enable", d, 1);
    check(!early_irq_o, "R7 irq masked", early_irq_o, 0);
    wr(2'd1, 10'h27F);
    check(early_irq_o, "R7 irq enabled", early_irq_o, 1);
    wr(2'd2, 10'h001);
    rd(2'd2, d); check(d == 32'h1, "R7 write 1 keeps flag", d, 1);
    wr(2'd2, 10'h000);
    rd(2'd2, d); check(d == 32'h0, "R7 write 0 clears", d, 0);
    check(!early_irq_o, "R7 irq cleared", early_irq_o, 0);
    check(!wdg_reset_seen_o, "R5 unarmed passes 0x3F quietly", wdg_reset_seen_o, 0);

    finish_run();
  end
endmodule